// File: doc/BRIEF.md
# Translation Unit Downstream Request Dispatcher

This block sits at the outgoing side of an address-translation unit. Every request that the translation logic issues goes through it. A request is one of two kinds. A final forward is a translated transaction. A walk read is a page-table fetch. The block steers each request onto one of two downstream valid/ready channels. The main channel carries final forwards. The walk channel carries walk reads when a walk target is attached. When no walk target is attached, walk reads use the main channel, and the walk channel stays idle.

Each channel has its own in-order retry queue. A request may go straight downstream only when its channel's queue is empty. A request that finds a non-empty queue, or that the channel refuses, joins the tail of the queue. The queue presents its head downstream until the channel takes it, so a refusal holds the queue in place and nothing behind the head can overtake it.

Each time the main channel accepts a final forward, a transaction slot is freed. The block then pulses a retry indication to every upstream device port, so that stalled ports can try again.

Top module: `tu_req_dispatch`

## Requirements
- R1: While `rst_n` is low and for the first cycle after it, with `up_valid` low: both queues are empty, `main_valid` and `walk_valid` are low, every bit of `dev_retry` is 0, and `up_ready` is high.
- R2: When a request's queue is empty and its channel's ready is high, the request appears on that channel in the same cycle it is offered. It is not queued, and the channel shows no valid in the next cycle unless a new request arrives.
- R3: A request whose channel refuses it while its queue is empty is stored. It is then offered on that channel in every following cycle until the channel accepts it.
- R4: While a channel's queue holds entries, a newly accepted request goes behind them, even when the channel's ready is high. The channel shows the queue head, not the new request.
- R5: Each channel delivers requests in exactly the order they were accepted. The head stays valid and unchanged while the channel refuses it, and it leaves the queue only when the channel accepts it.
- R6: When the walk target is attached, requests with `up_walk`=1 go out only on the walk channel, and requests with `up_walk`=0 go out only on the main channel.
- R7: When the walk target is detached, requests with `up_walk`=1 go out on the main channel, in the same queue and order as final forwards. `walk_valid` stays low.
- R8: The attachment state is taken from `walk_attach` only while `rst_n` is low. Changes on `walk_attach` after reset do not alter routing.
- R9: Every bit of `dev_retry` is high for exactly one cycle, the cycle after the main channel accepts a request with `up_walk`=0. An accepted request with `up_walk`=1, on either channel, produces no pulse.
- R10: `up_ready` is low exactly when the queue that the offered request's kind routes to holds `DEPTH` entries. A full queue does not lower `up_ready` for the other kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| walk_attach | input | 1 | Walk target present; sampled only during reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted when high with `up_valid` |
| up_walk | input | 1 | Request kind: 1 walk read, 0 final forward |
| up_data | input | DATA_W | Request payload |
| main_valid | output | 1 | Main channel valid |
| main_ready | input | 1 | Main channel ready |
| main_data | output | DATA_W | Main channel payload |
| walk_valid | output | 1 | Walk channel valid |
| walk_ready | input | 1 | Walk channel ready |
| walk_data | output | DATA_W | Walk channel payload |
| dev_retry | output | N_DEV | One-cycle retry pulse, one bit per upstream device port |

## Verification
Some properties are checked by assertions on every cycle. A queue never takes a write when full and never takes a read when empty. A refused head stays valid and unchanged. The walk channel stays silent while detached. The attachment flag never moves outside reset. Each retry pulse follows a main-channel handoff of a final forward. Other behaviour shows only in the bench's scenarios against its own ordering model: that no request overtakes a queued one, that a direct pass happens only into an empty queue, that a walk-read handoff produces no pulse, and that walk reads merge into the main queue when detached.

// File: rtl/tu_req_dispatch_pkg.sv
// Shared definitions for the downstream request dispatcher.
// Assumes: no other package defines the same names.
package tu_req_dispatch_pkg;

    // Default sizing shared by the top and its lanes
    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_DEPTH  = 4;
    localparam int unsigned DEF_N_DEV  = 2;

    // Kind of an outgoing request
    typedef enum logic {
        KIND_FINAL = 1'b0,
        KIND_WALK  = 1'b1
    } req_kind_e;

endpackage

// File: rtl/tu_retry_fifo.sv
// In-order retry queue: a circular buffer with an occupancy counter.
// Assumes: the caller never writes when full and never reads when empty.
// A write and a read in the same cycle are allowed.
module tu_retry_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     store [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign rd_data = store[rd_ptr];

    // Write the payload into the tail slot
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_ptr] <= wr_data;
        end
    end

    // Advance the pointers and track the occupancy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (rd_en) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full); // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty); // R5

endmodule

// File: rtl/tu_req_lane.sv
// One downstream channel with its retry queue.
// An arriving request goes straight to the channel only when the queue is
// empty and the channel is ready. Otherwise it is queued at the tail.
// While the queue holds entries, the head is offered until it is taken.
// Assumes: the channel follows valid/ready, with a transfer when both are
// high at a rising edge.
module tu_req_lane #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    logic         q_empty;
    logic         q_full;
    logic [W-1:0] q_head;
    logic         q_push;
    logic         q_pop;
    logic         bypass_taken;

    // Direct path: an empty queue lets a request go out in the same cycle
    always_comb begin
        bypass_taken = q_empty && in_valid && out_ready;
        in_ready     = !q_full;
        out_valid    = !q_empty || in_valid;
        out_data     = q_empty ? in_data : q_head;
        q_push       = in_valid && !q_full && !bypass_taken;
        q_pop        = !q_empty && out_ready;
    end

    tu_retry_fifo #(
        .W     (W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (q_push),
        .wr_data (in_data),
        .rd_en   (q_pop),
        .rd_data (q_head),
        .empty   (q_empty),
        .full    (q_full)
    );

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_empty && !out_ready) |=> (out_valid && $stable(out_data))); // R5

endmodule

// File: rtl/tu_req_dispatch.sv
// Downstream request dispatcher for an address-translation unit.
// Routes final forwards to the main channel and walk reads to the walk
// channel. When no walk target is attached, walk reads take the main
// channel instead. Each channel keeps its own in-order retry queue.
// Each main-channel handoff of a final forward pulses dev_retry.
// Assumes: walk_attach is steady during reset, and the main channel is
// always present.
module tu_req_dispatch
    import tu_req_dispatch_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned DEPTH  = DEF_DEPTH,
    parameter int unsigned N_DEV  = DEF_N_DEV
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              walk_attach,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic              up_walk,
    input  logic [DATA_W-1:0] up_data,
    output logic              main_valid,
    input  logic              main_ready,
    output logic [DATA_W-1:0] main_data,
    output logic              walk_valid,
    input  logic              walk_ready,
    output logic [DATA_W-1:0] walk_data,
    output logic [N_DEV-1:0]  dev_retry
);
    localparam int unsigned MAIN_W = DATA_W + 1;

    req_kind_e         kind;
    logic              walk_en;
    logic              to_walk;
    logic              main_in_valid;
    logic              main_in_ready;
    logic              walk_in_valid;
    logic              walk_in_ready;
    logic [MAIN_W-1:0] main_in_data;
    logic [MAIN_W-1:0] main_out_data;
    logic              main_out_tag;
    logic              pulse_q;

    // Capture walk attachment once, during reset only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            walk_en <= walk_attach;
        end
    end

    // Steer the offered request by kind and attachment
    always_comb begin
        kind          = req_kind_e'(up_walk);
        to_walk       = (kind == KIND_WALK) && walk_en;
        main_in_valid = up_valid && !to_walk;
        walk_in_valid = up_valid && to_walk;
        main_in_data  = {(kind == KIND_WALK), up_data};
        up_ready      = to_walk ? walk_in_ready : main_in_ready;
    end

    tu_req_lane #(
        .W     (MAIN_W),
        .DEPTH (DEPTH)
    ) u_main_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (main_in_valid),
        .in_data   (main_in_data),
        .in_ready  (main_in_ready),
        .out_valid (main_valid),
        .out_ready (main_ready),
        .out_data  (main_out_data)
    );

    tu_req_lane #(
        .W     (DATA_W),
        .DEPTH (DEPTH)
    ) u_walk_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (walk_in_valid),
        .in_data   (up_data),
        .in_ready  (walk_in_ready),
        .out_valid (walk_valid),
        .out_ready (walk_ready),
        .out_data  (walk_data)
    );

    // Split the main-channel word into payload and kind tag
    always_comb begin
        main_data    = main_out_data[DATA_W-1:0];
        main_out_tag = main_out_data[DATA_W];
    end

    // Register a retry pulse when a final forward leaves on the main channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= main_valid && main_ready && !main_out_tag;
        end
    end

    // Fan the pulse out to every upstream device port
    for (genvar g = 0; g < N_DEV; g++) begin : g_dev_retry
        assign dev_retry[g] = pulse_q;
    end

    AST_WALK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !walk_en |-> !walk_valid); // R7
    AST_ATTACH_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(walk_en)); // R8
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> $past(main_valid && main_ready)); // R9
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q && !(main_valid && main_ready)) |=> !pulse_q); // R9

endmodule

// File: tb/tu_req_dispatch_tb.sv
`timescale 1ns/1ps
module tu_req_dispatch_tb;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned DEPTH  = 4;
    localparam int unsigned N_DEV  = 2;
    localparam int unsigned MQ     = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              walk_attach = 1'b1;
    logic              up_valid = 1'b0;
    logic              up_ready;
    logic              up_walk = 1'b0;
    logic [DATA_W-1:0] up_data = '0;
    logic              main_valid;
    logic              main_ready = 1'b0;
    logic [DATA_W-1:0] main_data;
    logic              walk_valid;
    logic              walk_ready = 1'b0;
    logic [DATA_W-1:0] walk_data;
    logic [N_DEV-1:0]  dev_retry;

    always #10 clk = ~clk;

    tu_req_dispatch #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .N_DEV  (N_DEV)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .walk_attach (walk_attach),
        .up_valid    (up_valid),
        .up_ready    (up_ready),
        .up_walk     (up_walk),
        .up_data     (up_data),
        .main_valid  (main_valid),
        .main_ready  (main_ready),
        .main_data   (main_data),
        .walk_valid  (walk_valid),
        .walk_ready  (walk_ready),
        .walk_data   (walk_data),
        .dev_retry   (dev_retry)
    );

    int n_checks = 0;
    int n_err    = 0;

    // Reference model: the accepted, not yet delivered requests per channel
    logic [DATA_W-1:0] mq_d [MQ];
    logic              mq_w [MQ];
    int                mq_n;
    logic [DATA_W-1:0] wq_d [MQ];
    int                wq_n;
    logic              walk_en_m;
    logic              prev_pulse;

    // Outputs sampled in the last step
    logic              s_rdy, s_mv, s_wv;
    logic [DATA_W-1:0] s_md, s_wd;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [N_DEV-1:0] exp_retry(input logic p);
        return p ? {N_DEV{1'b1}} : '0;
    endfunction

    task automatic do_reset(input logic attach);
        @(negedge clk);
        rst_n = 1'b0; walk_attach = attach;
        up_valid = 1'b0; main_ready = 1'b0; walk_ready = 1'b0;
        repeat (3) @(negedge clk);
        #5;
        chk("R1 main_valid in reset", 64'(main_valid), 64'(0));
        chk("R1 walk_valid in reset", 64'(walk_valid), 64'(0));
        chk("R1 dev_retry in reset", 64'(dev_retry), 64'(0));
        @(negedge clk);
        rst_n = 1'b1;
        mq_n = 0; wq_n = 0; prev_pulse = 1'b0; walk_en_m = attach;
        #5;
        chk("R1 main_valid after reset", 64'(main_valid), 64'(0));
        chk("R1 walk_valid after reset", 64'(walk_valid), 64'(0));
        chk("R1 dev_retry after reset", 64'(dev_retry), 64'(0));
        chk("R1 up_ready after reset", 64'(up_ready), 64'(1));
    endtask

    // One cycle: drive, sample before the edge, check, update the model
    task automatic step(input logic v, input logic wk, input logic [DATA_W-1:0] d,
                        input logic mr, input logic wr);
        logic to_walk, e_rdy, e_mv, e_wv;
        logic [DATA_W-1:0] e_md, e_wd;
        @(negedge clk);
        up_valid = v; up_walk = wk; up_data = d; main_ready = mr; walk_ready = wr;
        #5;
        s_rdy = up_ready; s_mv = main_valid; s_md = main_data;
        s_wv = walk_valid; s_wd = walk_data;
        chk("R9 dev_retry", 64'(dev_retry), 64'(exp_retry(prev_pulse)));
        to_walk = wk && walk_en_m;
        e_rdy = to_walk ? (wq_n < DEPTH) : (mq_n < DEPTH);
        chk("R10 up_ready", 64'(s_rdy), 64'(e_rdy));
        e_mv = (mq_n > 0) || (v && !to_walk);
        e_md = (mq_n > 0) ? mq_d[0] : d;
        chk("R3 main_valid", 64'(s_mv), 64'(e_mv));
        if (e_mv) chk("R5 main_data order", 64'(s_md), 64'(e_md));
        e_wv = (wq_n > 0) || (v && to_walk);
        e_wd = (wq_n > 0) ? wq_d[0] : d;
        chk(walk_en_m ? "R6 walk_valid" : "R7 walk_valid", 64'(s_wv), 64'(e_wv));
        if (e_wv) chk("R6 walk_data order", 64'(s_wd), 64'(e_wd));
        if (v && e_rdy) begin
            if (to_walk) begin
                wq_d[wq_n] = d; wq_n++;
            end else begin
                mq_d[mq_n] = d; mq_w[mq_n] = wk; mq_n++;
            end
        end
        prev_pulse = 1'b0;
        if (e_mv && mr) begin
            prev_pulse = !mq_w[0];
            for (int i = 0; i < mq_n - 1; i++) begin
                mq_d[i] = mq_d[i+1]; mq_w[i] = mq_w[i+1];
            end
            mq_n--;
        end
        if (e_wv && wr) begin
            for (int i = 0; i < wq_n - 1; i++) wq_d[i] = wq_d[i+1];
            wq_n--;
        end
    endtask

    task automatic random_phase(input int cycles, input int p_valid, input int p_mr,
                                input int p_wr, input logic toggle_attach);
        for (int c = 0; c < cycles; c++) begin
            if (toggle_attach && ($urandom % 50 == 0)) walk_attach = ~walk_attach;
            step(($urandom % 100) < p_valid, $urandom % 2, $urandom,
                 ($urandom % 100) < p_mr, ($urandom % 100) < p_wr);
        end
        for (int c = 0; c < 3 * DEPTH; c++) step(1'b0, 1'b0, '0, 1'b1, 1'b1);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset(1'b1);

        // R2: direct pass with an empty queue and a ready channel
        step(1'b1, 1'b0, 32'hA0A0_0001, 1'b1, 1'b0);
        chk("R2 bypass valid", 64'(s_mv), 64'(1));
        chk("R2 bypass data", 64'(s_md), 64'hA0A0_0001);
        step(1'b0, 1'b0, '0, 1'b1, 1'b0);
        chk("R2 nothing queued", 64'(s_mv), 64'(0));

        // R3: a refused request is kept and offered again
        step(1'b1, 1'b0, 32'hB0B0_0002, 1'b0, 1'b0);
        step(1'b0, 1'b0, '0, 1'b0, 1'b0);
        chk("R3 held valid", 64'(s_mv), 64'(1));
        chk("R3 held data", 64'(s_md), 64'hB0B0_0002);
        step(1'b0, 1'b0, '0, 1'b1, 1'b0);

        // R4: a new request goes behind a queued one even when ready
        step(1'b1, 1'b0, 32'hC0C0_0003, 1'b0, 1'b0);
        step(1'b1, 1'b0, 32'hD0D0_0004, 1'b1, 1'b0);
        chk("R4 head first", 64'(s_md), 64'hC0C0_0003);
        step(1'b0, 1'b0, '0, 1'b1, 1'b0);
        chk("R4 follower next", 64'(s_md), 64'hD0D0_0004);

        // R10: fill the main queue, the walk kind stays accepted
        for (int k = 0; k < DEPTH; k++) step(1'b1, 1'b0, 32'(k + 16), 1'b0, 1'b0);
        step(1'b1, 1'b0, 32'hEEEE_0005, 1'b0, 1'b0);
        chk("R10 full main blocks", 64'(s_rdy), 64'(0));
        step(1'b1, 1'b1, 32'hF0F0_0006, 1'b0, 1'b0);
        chk("R10 walk kind unaffected", 64'(s_rdy), 64'(1));
        for (int k = 0; k < 2 * DEPTH; k++) step(1'b0, 1'b0, '0, 1'b1, 1'b1);

        // R9: a walk read taken on the walk channel gives no pulse
        step(1'b1, 1'b1, 32'h1111_0007, 1'b0, 1'b1);
        chk("R6 walk routed", 64'(s_wv), 64'(1));
        step(1'b0, 1'b0, '0, 1'b0, 1'b0);
        chk("R9 no pulse for walk", 64'(dev_retry), 64'(0));

        // R8: attachment changes after reset are ignored
        walk_attach = 1'b0;
        step(1'b1, 1'b1, 32'h2222_0008, 1'b1, 1'b1);
        chk("R8 still on walk channel", 64'(s_wv), 64'(1));
        chk("R8 walk data", 64'(s_wd), 64'h2222_0008);
        chk("R8 main idle", 64'(s_mv), 64'(0));

        random_phase(3000, 70, 60, 60, 1'b1);
        random_phase(1500, 90, 20, 30, 1'b1);

        // R7: detached, walk reads use the main channel
        do_reset(1'b0);
        step(1'b1, 1'b1, 32'h3333_0009, 1'b1, 1'b1);
        chk("R7 walk read on main", 64'(s_mv), 64'(1));
        chk("R7 walk read data", 64'(s_md), 64'h3333_0009);
        chk("R7 walk channel idle", 64'(s_wv), 64'(0));
        step(1'b0, 1'b0, '0, 1'b0, 1'b0);
        chk("R9 no pulse for walk on main", 64'(dev_retry), 64'(0));
        random_phase(3000, 70, 50, 50, 1'b1);

        do_reset(1'b1);
        random_phase(2000, 50, 90, 10, 1'b0);
        finish_run();
    end
endmodule